// File: doc/BRIEF.md
# Write-Once Snooping Coherence Controller

This block tracks coherence state for a small direct-mapped set of cache lines on a shared snooping bus. It follows a hybrid write policy. The first processor write to a line held clean and possibly shared goes through to memory as one word. That bus write tells every other cache to drop its copy. Later writes to the same line stay local, and the line becomes dirty. Each line is Invalid, Valid (clean, possibly shared), Reserved (written through once, sole copy, memory current) or Dirty (sole copy, memory stale).

The processor side presents a request with a write flag and an address. The controller reports hit or miss at once. It completes local hits in the same cycle and stalls everything else until its single bus transaction is granted. On the bus side it raises a request with a command and address, and holds it until a grant arrives. The grant cycle is the cycle the transaction is performed. The snoop side takes other caches' transactions one per cycle. When this cache owns dirty data that a snooped read must return, the controller raises a memory-inhibit output in that cycle. Data storage, arbitration and memory sit outside.

Top module: `wonce_ctrl`

## Requirements
- R1: After reset every line is Invalid: no address hits, and there is no bus request, no stall and no inhibit.
- R2: A processor read that hits (Valid, Reserved or Dirty) completes in the cycle it is presented, raises no bus request and leaves the line's state unchanged.
- R3: A processor read miss issues bus command 0 (read) for the requested address. cpu_done rises in the grant cycle, and the line is then Valid.
- R4: A processor write that hits a Valid line issues bus command 2 (single-word write-through). On grant the line becomes Reserved.
- R5: A processor write that hits a Reserved line completes locally and makes it Dirty. A write hitting a Dirty line completes locally and leaves it Dirty.
- R6: A processor write miss issues bus command 1 (read-exclusive). On grant the line is installed Dirty.
- R7: A snooped read (command 0) that matches a held line turns Reserved or Dirty into Valid. snp_inhibit is high in that cycle only if the line was Dirty, and a Valid line is unchanged.
- R8: A snooped read-exclusive (1) or write-through (2) that matches a held line makes it Invalid. snp_inhibit is high only for a read-exclusive of a Dirty line. A snoop whose tag differs from the held tag changes nothing.
- R9: A miss on an index whose line is Dirty with another tag first issues command 3 (writeback) for the old address, with no completion. The fill follows. A Valid or Reserved victim is replaced with no writeback.
- R10: Once raised, bus_req stays high until bus_gnt. Only one transaction is outstanding, and cpu_stall stays high until its completion.
- R11: A processor request whose index equals that of a snoop in the same cycle is not accepted in that cycle. It is evaluated against the post-snoop state in a later cycle.
- R12: The bus command is chosen from the line state at grant time. A pending write-through whose line a snoop invalidates is therefore performed as a read-exclusive, and the line ends Dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request present |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | AW | Request line address (low IDX_W bits index, rest tag) |
| cpu_hit | output | 1 | cpu_addr matches a non-Invalid line |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_stall | output | 1 | Processor must wait |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | 0 read, 1 read-exclusive, 2 write-through, 3 writeback |
| bus_addr | output | AW | Line address of the transaction |
| bus_gnt | input | 1 | Transaction performed this cycle |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | AW | Snooped line address |
| snp_inhibit | output | 1 | Memory inhibited; this cache supplies dirty data |

## Verification
The bench walks one line through every start state and every processor or snoop event. It reads the resulting state back through two separate probes: a write tells Valid from Reserved/Dirty, and a snooped read tells Dirty from the clean states. A design that skipped Reserved would show a write-through on the second write or assert inhibit too early. A design that dirtied the line on the first write would never send the write-through that invalidates other copies.

Directed cases cover the remaining corner cases. A dirty victim must produce a writeback without completion before its fill, and a design that dropped it would lose data. A Reserved victim must stay silent. A processor/snoop collision on the same index must not use stale state. A pending write-through whose line is invalidated before grant must become a read-exclusive; a design that kept the latched command would upgrade a line it no longer holds.

// File: rtl/wonce_ctrl.sv
`timescale 1ns/1ps
module wonce_ctrl #(
  parameter int AW    = 8,
  parameter int IDX_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  output logic          cpu_hit,
  output logic          cpu_done,
  output logic          cpu_stall,
  output logic          bus_req,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  input  logic          bus_gnt,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_inhibit
);
  localparam int NL = 1 << IDX_W;
  localparam int TW = AW - IDX_W;

  localparam logic [1:0] ST_I = 2'd0, ST_V = 2'd1, ST_R = 2'd2, ST_D = 2'd3;
  localparam logic [1:0] OP_RD = 2'd0, OP_RDX = 2'd1, OP_WT = 2'd2, OP_WB = 2'd3;

  logic [NL-1:0][1:0]    lst;
  logic [NL-1:0][TW-1:0] ltag;
  logic                  busy;
  logic [AW-1:0]         raddr;
  logic                  rwe;

  wire [IDX_W-1:0] c_idx = cpu_addr[IDX_W-1:0];
  wire [TW-1:0]    c_tag = cpu_addr[AW-1:IDX_W];
  wire [1:0]       c_st  = lst[c_idx];

  wire [IDX_W-1:0] s_idx = snp_addr[IDX_W-1:0];
  wire [TW-1:0]    s_tag = snp_addr[AW-1:IDX_W];
  wire [1:0]       s_st  = lst[s_idx];
  wire             s_hit = snp_valid && s_st != ST_I && ltag[s_idx] == s_tag;

  wire [IDX_W-1:0] r_idx   = raddr[IDX_W-1:0];
  wire [TW-1:0]    r_tag   = raddr[AW-1:IDX_W];
  wire [1:0]       r_st    = lst[r_idx];
  wire             r_match = r_st != ST_I && ltag[r_idx] == r_tag;
  wire             need_wb = r_st == ST_D && ltag[r_idx] != r_tag;

  assign cpu_hit = c_st != ST_I && ltag[c_idx] == c_tag;

  wire s_conf   = snp_valid && s_idx == c_idx;
  wire local_ok = cpu_hit && (!cpu_we || c_st != ST_V);
  wire accept   = !busy && cpu_req && !s_conf;
  wire lhit     = accept && local_ok;
  wire fin      = busy && bus_gnt && !need_wb;

  always_comb begin
    if (need_wb)      bus_cmd = OP_WB;
    else if (!rwe)    bus_cmd = OP_RD;
    else if (r_match) bus_cmd = OP_WT;
    else              bus_cmd = OP_RDX;
  end

  assign bus_req     = busy;
  assign bus_addr    = need_wb ? {ltag[r_idx], r_idx} : raddr;
  assign cpu_done    = lhit || fin;
  assign cpu_stall   = busy || (cpu_req && !lhit);
  assign snp_inhibit = s_hit && s_st == ST_D && (snp_cmd == OP_RD || snp_cmd == OP_RDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lst   <= '0;
      ltag  <= '0;
      busy  <= 1'b0;
      raddr <= '0;
      rwe   <= 1'b0;
    end else begin
      if (s_hit) begin
        case (snp_cmd)
          OP_RD:         if (s_st != ST_V) lst[s_idx] <= ST_V;
          OP_RDX, OP_WT: lst[s_idx] <= ST_I;
          default: ;
        endcase
      end

      if (lhit && cpu_we) lst[c_idx] <= ST_D;

      if (accept && !local_ok) begin
        busy  <= 1'b1;
        raddr <= cpu_addr;
        rwe   <= cpu_we;
      end

      if (busy && bus_gnt) begin
        if (need_wb) begin
          lst[r_idx] <= ST_V;
        end else begin
          busy        <= 1'b0;
          ltag[r_idx] <= r_tag;
          case (bus_cmd)
            OP_RD:   lst[r_idx] <= ST_V;
            OP_WT:   lst[r_idx] <= ST_R;
            default: lst[r_idx] <= ST_D;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/wonce_ctrl_chk.sv
`timescale 1ns/1ps
module wonce_ctrl_chk #(
  parameter int AW    = 8,
  parameter int IDX_W = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic          cpu_hit,
  input logic          cpu_done,
  input logic          cpu_stall,
  input logic          bus_req,
  input logic [1:0]    bus_cmd,
  input logic          bus_gnt,
  input logic          snp_valid,
  input logic [1:0]    snp_cmd,
  input logic [AW-1:0] snp_addr,
  input logic          snp_inhibit
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req);

  // R10
  stall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> cpu_stall);

  // R2
  rd_hit_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cpu_we && cpu_hit && !bus_req && !snp_valid |-> cpu_done && !cpu_stall);

  // R9
  wb_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && bus_cmd == 2'd3 |-> !cpu_done);

  // R7
  inhibit_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_inhibit |-> snp_valid && (snp_cmd == 2'd0 || snp_cmd == 2'd1));

  // R7
  inhibit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && $past(snp_inhibit) && !$past(bus_gnt) && snp_addr == $past(snp_addr)
      |-> !snp_inhibit);
endmodule

bind wonce_ctrl wonce_ctrl_chk #(.AW(AW), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_hit(cpu_hit),
  .cpu_done(cpu_done), .cpu_stall(cpu_stall), .bus_req(bus_req), .bus_cmd(bus_cmd),
  .bus_gnt(bus_gnt), .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
  .snp_inhibit(snp_inhibit)
);

// File: tb/tb_wonce_ctrl.sv
`timescale 1ns/1ps
module tb_wonce_ctrl;
  localparam logic [1:0] RD = 2'd0, RDX = 2'd1, WT = 2'd2, WB = 2'd3;
  localparam int SI = 0, SV = 1, SR = 2, SD = 3;
  localparam logic [7:0] A = 8'h15;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0, bus_gnt = 0, snp_valid = 0;
  logic [7:0] cpu_addr = 0, snp_addr = 0;
  logic [1:0] snp_cmd = 0;
  logic cpu_hit, cpu_done, cpu_stall, bus_req, snp_inhibit;
  logic [1:0] bus_cmd;
  logic [7:0] bus_addr;
  int errs = 0, checks = 0;

  always #2 clk = ~clk;

  wonce_ctrl #(.AW(8), .IDX_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_hit(cpu_hit), .cpu_done(cpu_done), .cpu_stall(cpu_stall),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_inhibit(snp_inhibit));

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [7:0] a, output bit loc);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a;
    #0.5 loc = cpu_done;
    @(negedge clk);
    cpu_req = 0;
  endtask

  task automatic grant(input logic [1:0] ecmd, input logic [7:0] ea, input bit edone, input string req);
    #0.5;
    chk_eq(req, "bus_req", bus_req, 1);
    chk_eq(req, "bus_cmd", bus_cmd, ecmd);
    chk_eq(req, "bus_addr", bus_addr, ea);
    bus_gnt = 1;
    #0.5 chk_eq(req, "done at grant", cpu_done, edone);
    @(negedge clk);
    bus_gnt = 0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [7:0] a, output bit inh);
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    #0.5 inh = snp_inhibit;
    @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic op_cpu(input bit we, input logic [7:0] a, input int s, input string req);
    bit loc, eloc;
    eloc = we ? (s == SR || s == SD) : (s != SI);
    access(we, a, loc);
    chk_eq(req, "local completion", loc, eloc);
    if (!loc) grant(we ? ((s == SV) ? WT : RDX) : RD, a, 1, req);
  endtask

  task automatic setup(input int s, input logic [7:0] a);
    bit inh;
    snoop(RDX, a, inh);
    case (s)
      SV: op_cpu(0, a, SI, "R3");
      SR: begin op_cpu(0, a, SI, "R3"); op_cpu(1, a, SV, "R4"); end
      SD: op_cpu(1, a, SI, "R6");
      default: ;
    endcase
  endtask

  function automatic int nxt(input int s, input int op);
    case (op)
      0: return (s == SI) ? SV : s;
      1: return (s == SV) ? SR : SD;
      2: return (s == SI) ? SI : SV;
      3, 4: return SI;
      default: return s;
    endcase
  endfunction

  // probe 0 (write): 0 Invalid, 1 Valid, 2 Reserved/Dirty
  // probe 1 (snooped read): 0 Invalid, 1 Valid/Reserved, 3 Dirty
  function automatic int expect_probe(input int s, input int pk);
    if (pk == 0) return (s == SI) ? 0 : (s == SV) ? 1 : 2;
    return (s == SI) ? 0 : (s == SD) ? 3 : 1;
  endfunction

  task automatic probe(input int pk, input logic [7:0] a, output int code);
    bit loc, inh;
    logic [1:0] c;
    if (pk == 0) begin
      access(1, a, loc);
      if (loc) code = 2;
      else begin
        #0.5 c = bus_cmd;
        code = (c == WT) ? 1 : 0;
        grant(c, a, 1, "R5");
      end
    end else begin
      @(negedge clk);
      cpu_addr = a;
      #0.5;
      if (!cpu_hit) code = 0;
      else begin
        snoop(RD, a, inh);
        code = inh ? 3 : 1;
      end
    end
  endtask

  initial begin
    #800000;
    errs++; checks++;
    $display("FAIL R10 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    bit loc, inh;
    int code, hits;
    string rq [6] = '{"R2", "R5", "R7", "R8", "R8", "R8"};

    repeat (3) @(negedge clk);
    rst_n = 1;
    hits = 0;
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      cpu_addr = a[7:0];
      #0.5 hits += cpu_hit;
    end
    chk_eq("R1", "hits after reset", hits, 0);
    chk_eq("R1", "bus_req after reset", bus_req, 0);
    chk_eq("R1", "stall after reset", cpu_stall, 0);
    chk_eq("R1", "inhibit after reset", snp_inhibit, 0);

    for (int s = 0; s < 4; s++)
      for (int op = 0; op < 6; op++)
        for (int pk = 0; pk < 2; pk++) begin
          setup(s, A);
          case (op)
            0: op_cpu(0, A, s, (s == SI) ? "R3" : "R2");
            1: op_cpu(1, A, s, (s == SI) ? "R6" : (s == SV) ? "R4" : "R5");
            2: begin snoop(RD, A, inh); chk_eq("R7", "inhibit", inh, s == SD); end
            3: begin snoop(RDX, A, inh); chk_eq("R8", "inhibit", inh, s == SD); end
            4: begin snoop(WT, A, inh); chk_eq("R8", "inhibit", inh, 0); end
            default: begin snoop(RDX, A ^ 8'h80, inh); chk_eq("R8", "inhibit", inh, 0); end
          endcase
          probe(pk, A, code);
          chk_eq(rq[op], $sformatf("state s%0d op%0d probe%0d", s, op, pk), code,
                 expect_probe(nxt(s, op), pk));
        end

    // R9: dirty victim written back first, clean victims silent
    op_cpu(1, 8'h22, SI, "R6");
    access(0, 8'h42, loc);
    chk_eq("R9", "local on dirty victim", loc, 0);
    grant(WB, 8'h22, 0, "R9");
    grant(RD, 8'h42, 1, "R9");
    access(1, 8'h62, loc);
    grant(RDX, 8'h62, 1, "R9");
    op_cpu(0, 8'h03, SI, "R3");
    op_cpu(1, 8'h03, SV, "R4");
    access(0, 8'h43, loc);
    grant(RD, 8'h43, 1, "R9");

    // R10: request held while grant withheld
    access(0, 8'h10, loc);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #0.5;
      chk_eq("R10", "bus_req held", bus_req, 1);
      chk_eq("R10", "cmd held", bus_cmd, RD);
      chk_eq("R10", "addr held", bus_addr, 8'h10);
      chk_eq("R10", "stall held", cpu_stall, 1);
    end
    grant(RD, 8'h10, 1, "R10");
    #0.5;
    chk_eq("R10", "stall released", cpu_stall, 0);
    chk_eq("R10", "bus_req released", bus_req, 0);

    // R11: same-index snoop and processor write together
    op_cpu(1, 8'h10, SV, "R4");
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = 8'h10;
    snp_valid = 1; snp_cmd = RD; snp_addr = 8'h10;
    #0.5;
    chk_eq("R11", "done in collision", cpu_done, 0);
    chk_eq("R11", "stall in collision", cpu_stall, 1);
    chk_eq("R11", "no inhibit from Reserved", snp_inhibit, 0);
    @(negedge clk);
    snp_valid = 0;
    #0.5 chk_eq("R11", "write after collision not local", cpu_done, 0);
    @(negedge clk);
    cpu_req = 0;
    grant(WT, 8'h10, 1, "R11");

    // R12: pending write-through invalidated before grant
    access(1, 8'h43, loc);
    chk_eq("R12", "write to Valid not local", loc, 0);
    snoop(WT, 8'h43, inh);
    grant(RDX, 8'h43, 1, "R12");
    probe(1, 8'h43, code);
    chk_eq("R12", "ends Dirty", code, 3);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule